// File: doc/BRIEF.md
# SAR Conversion Sequencer with Serial Output

This block is the digital half of a 12-bit successive-approximation converter. A falling chip select puts the track/hold into hold. The block then runs a binary search on its own clock. On each step it drives a trial code to an external DAC and reads back an external comparator. The serial clock plays no part in the conversion.

While the search runs, the serial data line is enabled and held low. When the search finishes, the line goes high as an end-of-conversion marker. Each later falling serial-clock edge moves the next result bit onto the line, most significant bit first. Once the least significant bit has gone out, further edges give zeros. Raising chip select releases the data line, returns the track/hold to track, and abandons any search still running.

A low level on the wake input holds the block in power-down. When wake returns high, a fixed settling interval must pass before a conversion can start. Chip select, serial clock and wake all pass through two-flop synchronisers. Chip select and serial clock then go through a falling-edge detector.

The control machine has five states:
- POWER_DOWN: wake low.
- SETTLE: the wake-up interval.
- TRACK: idle and sampling, waiting for a chip-select fall.
- CONVERT: the search is running.
- SHIFT_OUT: the marker and the data are on the line.

Its transitions are:
- A low wake level moves any state to POWER_DOWN.
- POWER_DOWN goes to SETTLE.
- SETTLE goes to TRACK when the interval counter expires.
- TRACK goes to CONVERT on a chip-select fall.
- CONVERT goes back to TRACK when chip select is high (abort).
- CONVERT goes to SHIFT_OUT when the last search step is done.
- SHIFT_OUT goes to TRACK when chip select is high.

Top module: `sar_seq_serial`

## Requirements
- R1: After reset, and whenever the synchronised wake level is low, the block is in power-down: `pdown`=1, `hold`=0, `sdo_oe`=0. A wake drop during a conversion abandons it.
- R2: After wake returns high, the block spends WAKE_CYCLES cycles settling. A chip-select fall during that time starts no conversion.
- R3: A chip-select fall seen in TRACK sets `hold`=1 and `sdo_oe`=1 with `sdo`=0. These outputs first appear three clock edges after the pin change: two synchroniser edges plus the state register.
- R4: The search lasts NBITS*STEP_CYCLES clock cycles whatever the serial clock does. Serial-clock edges during the search are ignored.
- R5: The search decides one bit per step, starting at the MSB. Each step sets the trial bit and keeps it when `cmp_ge`=1. The result is the unsigned code floor(input) clamped to 0..2^NBITS-1: input 0 gives 0, and full scale or above gives 4095.
- R6: At the end of the search, `hold` returns to 0, `sdo` goes to 1 as the marker, and `dac_code` holds the result steady while chip select stays low.
- R7: After the marker, each synchronised serial-clock fall puts the next result bit on `sdo`, MSB first down to the LSB.
- R8: After the LSB, further serial-clock falls with chip select low give `sdo`=0.
- R9: A high chip select sets `hold`=0 and `sdo_oe`=0. If a conversion is running, it is abandoned, and the next chip-select fall starts a fresh one.
- R10: `sdo` is 0 whenever `sdo_oe` is 0, so the released line carries no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; data advances on its falling edge |
| wake | input | 1 | High = operate, low = power-down, asynchronous |
| cmp_ge | input | 1 | Comparator: held input is at or above the DAC level |
| hold | output | 1 | Track/hold control, 1 = hold |
| dac_code | output | NBITS | Trial code to the DAC; the result once the search is done |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Serial data enable (0 = high impedance) |
| pdown | output | 1 | Power-down state |

## Verification
The search is run with inputs at zero and at full scale, at the mid-scale pair 2047/2048 where every bit flips, and with the alternating patterns 0x555 and 0xAAA. These show whether each step keeps or drops its own bit, and whether the ties-keep rule holds at an exact DAC level. An input above full scale must clamp to 4095, and an input of 1 exercises the LSB alone. Reading sixteen clocks per frame separates correct ordering, marker placement and trailing zeros from off-by-one shifting. Toggling the serial clock during a search shows that the conversion does not depend on it. Chip-select raises and wake drops mid-search, plus a chip-select fall during settling, show that aborts and the wake-up guard leave nothing behind.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_POWER_DOWN = 3'd0,
        ST_SETTLE     = 3'd1,
        ST_TRACK      = 3'd2,
        ST_CONVERT    = 3'd3,
        ST_SHIFT_OUT  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sar_sync_level.sv
module sar_sync_level #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign level_o = chain[STAGES-1];

endmodule

// File: rtl/sar_fall_det.sv
module sar_fall_det #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= level_i;
    end

    assign fall_o = prev & ~level_i;

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int NBITS       = 12,
    parameter int STEP_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);

    localparam int TW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

    logic             busy;
    logic [NBITS-1:0] res;
    logic [NBITS-1:0] mask;
    logic             step_end;

    generate
        if (STEP_CYCLES == 1) begin : g_single
            assign step_end = 1'b1;
        end else begin : g_timer
            logic [TW-1:0] tmr;
            logic          last;
            assign last = (tmr == TW'(STEP_CYCLES - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         tmr <= '0;
                else if (start_i || !busy || last)  tmr <= '0;
                else                                tmr <= tmr + 1'b1;
            end
            assign step_end = last;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            res  <= '0;
            mask <= '0;
        end else if (start_i) begin
            busy <= 1'b1;
            res  <= '0;
            mask <= {1'b1, {(NBITS-1){1'b0}}};
        end else if (abort_i) begin
            busy <= 1'b0;
            mask <= '0;
        end else if (busy && step_end) begin
            if (cmp_i) res <= res | mask;
            mask <= mask >> 1;
            if (mask[0]) busy <= 1'b0;
        end
    end

    assign code_o   = res | mask;
    assign done_o   = busy & step_end & mask[0];
    assign result_o = res | (cmp_i ? mask : '0);

endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NBITS-1:0] data_i,
    input  logic             shift_i,
    output logic             msb_o
);

    logic [NBITS:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word <= '0;
        else if (load_i)  word <= {1'b1, data_i};
        else if (shift_i) word <= {word[NBITS-1:0], 1'b0};
    end

    assign msb_o = word[NBITS];

endmodule

// File: rtl/sar_seq_serial.sv
module sar_seq_serial
    import sar_seq_pkg::*;
#(
    parameter int NBITS       = 12,
    parameter int STEP_CYCLES = 2,
    parameter int WAKE_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csn,
    input  logic             sclk,
    input  logic             wake,
    input  logic             cmp_ge,
    output logic             hold,
    output logic [NBITS-1:0] dac_code,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             pdown
);

    localparam int WCW = $clog2(WAKE_CYCLES + 1);

    logic cs_lvl, cs_fall, sk_lvl, sk_fall, wk_lvl;

    sar_sync_level #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_i(csn), .level_o(cs_lvl));
    sar_fall_det #(.RST_VAL(1'b1)) u_cs_fall (
        .clk(clk), .rst_n(rst_n), .level_i(cs_lvl), .fall_o(cs_fall));
    sar_sync_level #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk), .level_o(sk_lvl));
    sar_fall_det #(.RST_VAL(1'b0)) u_sk_fall (
        .clk(clk), .rst_n(rst_n), .level_i(sk_lvl), .fall_o(sk_fall));
    sar_sync_level #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wake), .level_o(wk_lvl));

    seq_state_e       state, state_nx;
    logic [WCW-1:0]   wake_cnt;
    logic             settle_end;
    logic             search_done;
    logic [NBITS-1:0] search_res;
    logic             word_msb;
    logic             start_search, abort_search, load_word, shift_word;

    assign settle_end = (wake_cnt == WCW'(WAKE_CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POWER_DOWN;
        else        state <= state_nx;
    end

    // settle interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   wake_cnt <= '0;
        else if (state == ST_SETTLE)  wake_cnt <= wake_cnt + 1'b1;
        else                          wake_cnt <= '0;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!wk_lvl) begin
            state_nx = ST_POWER_DOWN;
        end else begin
            unique case (state)
                ST_POWER_DOWN: state_nx = ST_SETTLE;
                ST_SETTLE:     if (settle_end) state_nx = ST_TRACK;
                ST_TRACK:      if (cs_fall) state_nx = ST_CONVERT;
                ST_CONVERT: begin
                    if (cs_lvl)           state_nx = ST_TRACK;
                    else if (search_done) state_nx = ST_SHIFT_OUT;
                end
                ST_SHIFT_OUT:  if (cs_lvl) state_nx = ST_TRACK;
                default:       state_nx = ST_POWER_DOWN;
            endcase
        end
    end

    // control strobes to the datapath
    assign start_search = (state == ST_TRACK) && (state_nx == ST_CONVERT);
    assign abort_search = (state == ST_CONVERT) && (state_nx != ST_CONVERT)
                          && (state_nx != ST_SHIFT_OUT);
    assign load_word    = (state == ST_CONVERT) && (state_nx == ST_SHIFT_OUT);
    assign shift_word   = (state == ST_SHIFT_OUT) && (state_nx == ST_SHIFT_OUT) && sk_fall;

    // outputs from state
    always_comb begin
        hold   = 1'b0;
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        pdown  = 1'b0;
        unique case (state)
            ST_POWER_DOWN: pdown = 1'b1;
            ST_SETTLE:     ;
            ST_TRACK:      ;
            ST_CONVERT: begin
                hold   = 1'b1;
                sdo_oe = 1'b1;
            end
            ST_SHIFT_OUT: begin
                sdo_oe = 1'b1;
                sdo    = word_msb;
            end
            default: pdown = 1'b1;
        endcase
    end

    sar_search #(.NBITS(NBITS), .STEP_CYCLES(STEP_CYCLES)) u_search (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_search), .abort_i(abort_search), .cmp_i(cmp_ge),
        .code_o(dac_code), .done_o(search_done), .result_o(search_res));

    sar_out_shift #(.NBITS(NBITS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_i(load_word), .data_i(search_res),
        .shift_i(shift_word), .msb_o(word_msb));

endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic [NBITS-1:0] dac_code,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             pdown
);

    // R1: power-down drives nothing
    p_pdown_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> (!sdo_oe && !hold));

    // R3: while holding, line is enabled and low
    p_busy_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (sdo_oe && !sdo));

    // R6: leaving hold with the line still enabled shows the marker
    p_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && sdo_oe) |-> sdo);

    // R6: result on the DAC bus stays put while shifting
    p_code_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !hold && $past(sdo_oe && !hold)) |-> $stable(dac_code));

    // R10: released line carries no data
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

endmodule

bind sar_seq_serial sar_seq_checker #(.NBITS(NBITS)) u_sar_seq_checker (
    .clk(clk), .rst_n(rst_n), .hold(hold), .dac_code(dac_code),
    .sdo(sdo), .sdo_oe(sdo_oe), .pdown(pdown));

// File: tb/sar_seq_serial_bench.sv
`timescale 1ns/1ps
module sar_seq_serial_bench;

    localparam int N    = 12;
    localparam int STEP = 2;
    localparam int WAKE = 16;
    localparam int FULL = (1 << N) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, wake = 1'b1;
    logic cmp_ge;
    logic hold, sdo, sdo_oe, pdown;
    logic [N-1:0] dac_code;

    int vin = 0;
    int held_v = 0;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sar_seq_serial #(.NBITS(N), .STEP_CYCLES(STEP), .WAKE_CYCLES(WAKE), .SYNC_STAGES(2))
    u_sar_seq_serial (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .wake(wake),
        .cmp_ge(cmp_ge), .hold(hold), .dac_code(dac_code),
        .sdo(sdo), .sdo_oe(sdo_oe), .pdown(pdown));

    // analog side: sample on hold, compare against the DAC level
    always @(posedge hold) held_v = vin;
    assign cmp_ge = (held_v >= int'(dac_code));

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phases: 0 power-down, 1 settle, 2 track, 3 convert, 4 shift-out
    int m_phase = 0, m_cnt = 0, m_samp = 0;
    logic [N:0] m_word = '0;
    bit c1 = 1, c2 = 1, c3 = 1, s1 = 0, s2 = 0, s3 = 0, w1 = 0, w2 = 0;
    bit cf, sf, cl, wl;

    function automatic int expect_code(input int v);
        if (v < 0) return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_word = '0;
            c1 = 1; c2 = 1; c3 = 1; s1 = 0; s2 = 0; s3 = 0; w1 = 0; w2 = 0;
        end else begin
            cf = c3 & ~c2; sf = s3 & ~s2; cl = c2; wl = w2;
            c3 = c2; c2 = c1; c1 = csn;
            s3 = s2; s2 = s1; s1 = sclk;
            w2 = w1; w1 = wake;
            if (!wl) begin
                m_phase = 0;
            end else begin
                case (m_phase)
                    0: begin m_phase = 1; m_cnt = 0; end
                    1: if (m_cnt == WAKE - 1) m_phase = 2; else m_cnt++;
                    2: if (cf) begin m_phase = 3; m_cnt = 0; m_samp = vin; end
                    3: if (cl) m_phase = 2;
                       else if (m_cnt == N * STEP - 1) begin
                           m_phase = 4;
                           m_word = {1'b1, N'(expect_code(m_samp))};
                       end else m_cnt++;
                    4: if (cl) m_phase = 2;
                       else if (sf) m_word = {m_word[N-1:0], 1'b0};
                    default: m_phase = 0;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1", "pdown", int'(pdown), int'(m_phase == 0));
            check("R3", "hold", int'(hold), int'(m_phase == 3));
            check("R9", "sdo_oe", int'(sdo_oe), int'(m_phase == 3 || m_phase == 4));
            check("R7", "sdo", int'(sdo), int'(m_phase == 4 && m_word[N]));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; cycles(4);
        sclk = 1'b0; cycles(4);
    endtask

    task automatic convert_and_read(input int v, input bit wiggle);
        int n = 0;
        int code = 0;
        int exp = expect_code(v);
        vin = v;
        @(negedge clk); csn = 1'b0;
        if (wiggle) begin
            // R4: serial clock activity during the search is ignored
            repeat (3) begin sclk = 1'b1; @(negedge clk); n++; sclk = 1'b0; @(negedge clk); n++; end
        end
        while (!(sdo_oe && sdo) && n < 400) begin @(negedge clk); n++; end
        check("R4", "cycles to marker", n, N * STEP + 3);
        check("R6", "hold after search", int'(hold), 0);
        check("R5", "dac_code result", int'(dac_code), exp);
        for (int i = 0; i < N; i++) begin
            sclk_pulse();
            code = (code << 1) | int'(sdo);
        end
        check("R7", "shifted code", code, exp);
        for (int i = 0; i < 4; i++) begin
            sclk_pulse();
            check("R8", "trailing bit", int'(sdo), 0);
        end
        check("R6", "dac_code steady", int'(dac_code), exp);
        csn = 1'b1; cycles(4);
        check("R9", "oe after cs high", int'(sdo_oe), 0);
        check("R10", "sdo after release", int'(sdo), 0);
        cycles(3);
    endtask

    initial begin : main
        cycles(4);
        check("R1", "reset pdown", int'(pdown), 1);
        check("R1", "reset hold", int'(hold), 0);
        check("R1", "reset oe", int'(sdo_oe), 0);
        rst_n = 1'b1;
        // R2: chip select falls inside the settle window
        cycles(6); csn = 1'b0; cycles(3); csn = 1'b1;
        cycles(WAKE + 6);
        check("R2", "no conversion during settle", int'(sdo_oe), 0);
        check("R2", "no hold during settle", int'(hold), 0);

        convert_and_read(0, 1'b0);
        convert_and_read(FULL, 1'b0);
        convert_and_read(2048, 1'b1);
        convert_and_read(2047, 1'b0);
        convert_and_read(12'h555, 1'b0);
        convert_and_read(12'hAAA, 1'b1);
        convert_and_read(5000, 1'b0);
        convert_and_read(1, 1'b0);

        // R9: abort by raising chip select mid-search
        vin = 3000;
        csn = 1'b0; cycles(10);
        check("R9", "hold mid-search", int'(hold), 1);
        csn = 1'b1; cycles(4);
        check("R9", "hold after abort", int'(hold), 0);
        check("R9", "oe after abort", int'(sdo_oe), 0);
        convert_and_read(3000, 1'b0);

        // R1: wake drop mid-search
        csn = 1'b0; cycles(8);
        wake = 1'b0; cycles(4);
        check("R1", "pdown after wake drop", int'(pdown), 1);
        check("R1", "hold after wake drop", int'(hold), 0);
        check("R1", "oe after wake drop", int'(sdo_oe), 0);
        csn = 1'b1; wake = 1'b1;
        cycles(WAKE + 8);
        convert_and_read(1234, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule